// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast system clock into the two timing strobes a serial port needs. The first is a sample strobe whose average period is (P + 1 + M/16) system clocks. P is a 24-bit integer prescale and M is a 4-bit fraction in sixteenths. The second is a bit strobe, which fires on every sixteenth sample strobe and so sets the asynchronous bit rate. Both strobes are one system clock wide.

The fraction works as a 4-bit phase accumulator. It adds M at the start of every sample period. A period in which that addition carries out lasts P + 2 clocks; every other period lasts P + 1 clocks. Over any sixteen consecutive periods, exactly M of them are one clock longer. For example, with a 40 MHz clock, P = 20 and M = 10 give a bit period of 346 clocks, which is about 115607 baud.

The configuration word is sampled only when a new sample period begins. Dropping the enable, or asserting the synchronous reset, clears the counters and the accumulator and forces both strobes low.

Top module: `frac_baud_gen`

## Requirements
- R1: The configuration word carries P in bits 23:0 and M in bits 27:24. Bits 31:28 have no effect on either strobe.
- R2: With M = 0, every sample period lasts exactly P + 1 system clocks.
- R3: Every sample period lasts P + 1 or P + 2 clocks. Any sixteen consecutive periods together last 16·(P+1) + M clocks.
- R4: With P = 0 and M = 0, the sample strobe is high on every enabled clock cycle.
- R5: The bit strobe is a single-cycle pulse. It coincides with every sixteenth sample strobe, and the first one comes with the sixteenth sample strobe after start.
- R6: While the enable is low or reset is high, both strobes are low and all internal state is cleared. After start, the first sample strobe is seen P + 1 clocks after the first enabled edge, and the first period is never lengthened.
- R7: A configuration change made part-way through a sample period leaves that period's length unchanged. The change sets the length of the following period.
- R8: With P = 20 and M = 10, consecutive bit strobes are 346 system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low clears and silences the block |
| cfg_i | input | 32 | Configuration word: P in 23:0, M in 27:24 |
| samp_o | output | 1 | Sample strobe, one clock wide |
| bit_o | output | 1 | Bit strobe, one clock wide |

## Verification
The bench measures the gap between strobes over sixteen periods for fractions of 0, 1, 5, 8, 10 and 15. An accumulator that drops the carry, or that adds M in the wrong place, shows up as a wrong total or as a period of P + 3. The P = 0 row catches a reload that needs a spare cycle; such a design would emit only every other clock. A design that latches the configuration at once would stretch or cut the period in flight. A bit divider that is off by one would misplace the first bit strobe relative to the sixteenth sample strobe. Reset and enable are dropped mid-run to confirm that the outputs go quiet and that the first-period latency comes back unchanged.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int PRE_W  = 24;  // integer prescale width
  localparam int FRAC_W = 4;   // fraction width, sixteenths
  localparam int CFG_W  = 32;  // configuration word width
  localparam int M_LSB  = 24;  // lowest bit of the fraction field
  localparam int OVS    = 16;  // sample strobes per bit
endpackage

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] phase_q;

  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] ph,
                                                input logic [FRAC_W-1:0] m);
    return {1'b0, ph} + {1'b0, m};
  endfunction

  logic [FRAC_W:0] sum;
  assign sum     = frac_step(phase_q, frac_i);
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i) begin
    if (clr_i)       phase_q <= '0;
    else if (step_i) phase_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fbg_period_ctr.sv
module fbg_period_ctr #(
  parameter int PRE_W = fbg_pkg::PRE_W
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             ext_i,
  output logic             load_o,
  output logic             tick_o
);
  localparam int CW = PRE_W + 1;

  logic [CW-1:0] remain_q;
  logic          active_q;

  function automatic logic [CW-1:0] period_last(input logic [PRE_W-1:0] p, input logic e);
    return {1'b0, p} + CW'(e);
  endfunction

  assign tick_o = active_q && (remain_q == '0);
  assign load_o = run_i && (!active_q || remain_q == '0);

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      remain_q <= '0;
      active_q <= 1'b0;
    end else if (load_o) begin
      remain_q <= period_last(pre_i, ext_i);
      active_q <= 1'b1;
    end else if (active_q) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div #(
  parameter int OVS = fbg_pkg::OVS
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic samp_i,
  output logic bit_o
);
  localparam int W = $clog2(OVS);

  logic [W-1:0] seen_q;

  assign bit_o = samp_i && (seen_q == W'(OVS - 1));

  always_ff @(posedge clk_i) begin
    if (clr_i)       seen_q <= '0;
    else if (bit_o)  seen_q <= '0;
    else if (samp_i) seen_q <= seen_q + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int PRE_W  = fbg_pkg::PRE_W,
  parameter int FRAC_W = fbg_pkg::FRAC_W,
  parameter int CFG_W  = fbg_pkg::CFG_W,
  parameter int M_LSB  = fbg_pkg::M_LSB,
  parameter int OVS    = fbg_pkg::OVS
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             samp_o,
  output logic             bit_o
);
  function automatic logic [PRE_W-1:0] cfg_pre(input logic [CFG_W-1:0] c);
    return c[PRE_W-1:0];
  endfunction

  function automatic logic [FRAC_W-1:0] cfg_frac(input logic [CFG_W-1:0] c);
    return c[M_LSB +: FRAC_W];
  endfunction

  // Spare high configuration bits are not decoded.
  logic cfg_unused;
  assign cfg_unused = ^cfg_i[CFG_W-1:M_LSB+FRAC_W];

  // Named internal events.
  logic run;
  logic clr;
  logic period_load;
  logic frac_carry;
  logic period_tick;
  logic bit_raw;

  assign run = en_i && !rst_i;
  assign clr = !run;

  fbg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i  (clk_i),
    .clr_i  (clr),
    .step_i (period_load),
    .frac_i (cfg_frac(cfg_i)),
    .carry_o(frac_carry)
  );

  fbg_period_ctr #(.PRE_W(PRE_W)) u_ctr (
    .clk_i (clk_i),
    .clr_i (clr),
    .run_i (run),
    .pre_i (cfg_pre(cfg_i)),
    .ext_i (frac_carry),
    .load_o(period_load),
    .tick_o(period_tick)
  );

  assign samp_o = period_tick && run;

  fbg_bit_div #(.OVS(OVS)) u_div (
    .clk_i (clk_i),
    .clr_i (clr),
    .samp_i(samp_o),
    .bit_o (bit_raw)
  );

  assign bit_o = bit_raw && run;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int PRE_W  = fbg_pkg::PRE_W,
  parameter int FRAC_W = fbg_pkg::FRAC_W,
  parameter int CFG_W  = fbg_pkg::CFG_W,
  parameter int M_LSB  = fbg_pkg::M_LSB,
  parameter int OVS    = fbg_pkg::OVS
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             samp_i,
  input logic             bit_i
);
  localparam int GW = PRE_W + 2;
  localparam int SW = $clog2(OVS) + 1;

  logic              started;
  logic [PRE_W-1:0]  chk_p;
  logic [FRAC_W-1:0] chk_m;
  logic [GW-1:0]     gap;
  logic [SW-1:0]     scount;
  logic              chk_unused;
  logic              ld;

  assign chk_unused = ^{cfg_i[CFG_W-1:M_LSB+FRAC_W], cfg_i[M_LSB-1:PRE_W]};
  assign ld = en_i && (!started || samp_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      started <= 1'b0;
      chk_p   <= '0;
      chk_m   <= '0;
      gap     <= '0;
      scount  <= '0;
    end else begin
      started <= 1'b1;
      if (ld) begin
        chk_p <= cfg_i[PRE_W-1:0];
        chk_m <= cfg_i[M_LSB +: FRAC_W];
        gap   <= GW'(1);
      end else begin
        gap <= gap + 1'b1;
      end
      if (bit_i)       scount <= '0;
      else if (samp_i) scount <= scount + 1'b1;
    end
  end

  assert_quiet_off_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> (!samp_i && !bit_i));

  assert_len_max_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && en_i) |-> (gap <= GW'(chk_p) + GW'(2)));

  assert_len_min_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && samp_i) |-> (gap >= GW'(chk_p) + GW'(1)));

  assert_m0_exact_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && en_i && chk_m == '0 && gap == GW'(chk_p) + GW'(1)) |-> samp_i);

  assert_p0_every_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && en_i && chk_p == '0 && chk_m == '0) |-> samp_i);

  assert_bit_on_samp_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_i |-> samp_i);

  assert_bit_sixteenth_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (samp_i && en_i) |-> (bit_i == (scount == SW'(OVS - 1))));
endmodule

bind frac_baud_gen fbg_checker #(
  .PRE_W(PRE_W), .FRAC_W(FRAC_W), .CFG_W(CFG_W), .M_LSB(M_LSB), .OVS(OVS)
) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .en_i  (en_i),
  .cfg_i (cfg_i),
  .samp_i(samp_o),
  .bit_i (bit_o)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] cfg = '0;
  logic        samp;
  logic        bitt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  frac_baud_gen u_dut (
    .clk_i (clk), .rst_i (rst), .en_i (en), .cfg_i (cfg),
    .samp_o(samp), .bit_o (bitt)
  );

  // {configuration word, expected clocks over sixteen periods = 16*(P+1)+M}
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0003, 32'd64},
    {32'h0500_0003, 32'd69},
    {32'hF500_0003, 32'd69},
    {32'h0000_0000, 32'd16},
    {32'h0F00_0000, 32'd31},
    {32'h0800_0007, 32'd136},
    {32'h0A00_0014, 32'd346},
    {32'h0100_0001, 32'd33}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic [31:0] c, input int exp_total);
    int p = int'(c[23:0]);
    int m = int'(c[27:24]);
    int k = 0, n = 0, first_k = 0, last_k = 0, prev_k = 0;
    int bits = 0, bit_at = 0, bad_len = 0, bad_bit = 0;
    string tag;
    tag = (c[31:28] != 4'h0) ? "R1 R3 total" : "R3 total";
    en = 1'b0;
    cfg = c;
    @(negedge clk);
    @(negedge clk);
    check(samp == 1'b0 && bitt == 1'b0, "R6 idle quiet", int'(samp), 0);
    en = 1'b1;
    while (n < 17 && k < 5000) begin
      @(negedge clk);
      k++;
      if (samp) begin
        n++;
        if (n == 1) first_k = k;
        else begin
          int d = k - prev_k;
          if (d != p + 1 && !(m != 0 && d == p + 2)) bad_len++;
        end
        prev_k = k;
        if (n == 17) last_k = k;
      end
      if (bitt) begin
        bits++;
        bit_at = n;
        if (!samp) bad_bit++;
      end
    end
    check(first_k == p + 1, "R6 first latency", first_k, p + 1);
    check(last_k - first_k == exp_total, tag, last_k - first_k, exp_total);
    check(bad_len == 0, (m == 0) ? "R2 period length" : "R3 period length", bad_len, 0);
    check(bits == 1 && bit_at == 16 && bad_bit == 0, "R5 bit strobe", bit_at, 16);
    if (p == 0 && m == 0)
      check(bad_len == 0 && last_k - first_k == 16, "R4 every cycle", last_k - first_k, 16);
    en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, d1, d2, b1, b2;
    // Reset state, with enable already high.
    cfg = 32'h0000_0002;
    en  = 1'b1;
    repeat (4) @(negedge clk);
    check(samp == 1'b0 && bitt == 1'b0, "R6 reset quiet", int'(samp), 0);
    rst = 1'b0;
    en  = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) measure(VEC[i][63:32], int'(VEC[i][31:0]));

    // R7: a change made mid-period applies from the next period.
    cfg = 32'h0000_0009;
    en  = 1'b1;
    k = 0;
    while (!samp && k < 100) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    cfg = 32'h0000_0002;
    d1 = 3;
    @(negedge clk);
    while (!samp && d1 < 100) begin d1++; @(negedge clk); end
    d1++;
    d2 = 0;
    @(negedge clk);
    d2 = 1;
    while (!samp && d2 < 100) begin @(negedge clk); d2++; end
    check(d1 == 10, "R7 old period kept", d1, 10);
    check(d2 == 3, "R7 new period used", d2, 3);

    // R6: dropping enable silences at once.
    en = 1'b0;
    #1;
    check(samp == 1'b0 && bitt == 1'b0, "R6 disable quiet", int'(samp), 0);
    @(negedge clk);

    // R6: reset mid-run, then restart latency.
    cfg = 32'h0300_0004;
    en  = 1'b1;
    repeat (13) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(samp == 1'b0 && bitt == 1'b0, "R6 reset mid-run", int'(samp), 0);
    rst = 1'b0;
    k = 0;
    @(negedge clk);
    k = 1;
    while (!samp && k < 100) begin @(negedge clk); k++; end
    check(k == 5, "R6 latency after reset", k, 5);

    // R8: bit strobe spacing at P=20, M=10.
    en = 1'b0;
    cfg = 32'h0A00_0014;
    @(negedge clk);
    en = 1'b1;
    k = 0; b1 = -1; b2 = -1;
    while (b2 < 0 && k < 2000) begin
      @(negedge clk);
      k++;
      if (bitt) begin
        if (b1 < 0) b1 = k;
        else b2 = k;
      end
    end
    check(b2 - b1 == 346, "R8 bit spacing", b2 - b1, 346);
    en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule